// File: doc/BRIEF.md
# Direct-Mapped Data Address Translator

This block translates 32-bit data addresses for a load/store unit using 8 KB pages. It keeps a single-way table of 64 sets. Each set has a match half and a translate half. The match half holds a valid flag, a 4-bit context tag and the upper virtual page bits. The translate half holds the physical page number, six cache-control attribute bits and four access-permission bits.

Each cycle the load/store unit may present an access. The access gives the virtual address, a user/supervisor flag, a read/write flag and a translation-enable flag. One cycle later the block returns registered results: hit or miss, the physical address, a cache-inhibit flag and a permission-fault flag. When translation is off the address passes through unchanged, and the upper half of the address space is treated as uncached.

Software fills and inspects both halves of the table through a special-register port. One address bit of that port picks the half, and the low bits pick the set. The table itself never walks page tables; a miss is only reported.

Top module: `dxl_tlb`

## Requirements
- R1: After a synchronous reset every set is invalid, so any enabled lookup misses until software writes a match entry with bit 0 set.
- R2: An enabled lookup selects the set with VA[18:13]. It hits only when that set's valid bit is 1 and its stored tag equals VA[31:19]. Otherwise `res_miss` is 1, and `res_pa`, `res_ci` and `res_fault` are 0.
- R3: On a hit, `res_pa` is the stored page number (translate bits 31:13) joined with VA[12:0], and `res_ci` equals translate bit 1.
- R4: On a hit, the permission bit is picked by mode and direction: translate bit 6 for user read, bit 7 for user write, bit 8 for supervisor read, bit 9 for supervisor write. `res_fault` is 1 exactly when the picked bit is 0.
- R5: With `xl_en` low, `res_pa` equals the virtual address and `res_ci` equals VA[31]. `res_hit`, `res_miss` and `res_fault` stay 0.
- R6: Results are registered. They appear in the cycle after `acc_vld` is sampled, and `res_vld` repeats `acc_vld`. Every result output is 0 when no access was presented and during reset.
- R7: On the register port, `reg_addr[7]` = 1 writes the translate half and 0 writes the match half of set `reg_addr[5:0]`. A write is seen by lookups presented in the next cycle. A lookup sampled at the same edge as the write still sees the old entry.
- R8: `reg_rdata` is registered one cycle after `reg_addr`. For the match half it returns bit 0 valid, bits 4:1 context and bits 31:19 tag, with every other bit 0. For the translate half it returns bits 9:0 and 31:13 as written, with bits 12:10 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access presented this cycle |
| xl_en | input | 1 | Translation enabled for the access |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_va | input | 32 | Virtual address |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 8 | Register address: bit 7 selects the half, bits 5:0 select the set |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| res_vld | output | 1 | Result valid (registered `acc_vld`) |
| res_hit | output | 1 | Translation hit |
| res_miss | output | 1 | Translation miss |
| res_pa | output | 32 | Physical address |
| res_ci | output | 1 | Cache inhibit |
| res_fault | output | 1 | Permission fault |

## Verification
The assertions take for granted that reset is held for at least one clock before the first access. They also assume that software never writes the match half without meaning to validate or invalidate a set, because the empty-table property only tracks whether any match write has happened since reset.

The stimulus keeps to these assumptions. It holds reset for several cycles, writes the translate half of a set before the match half that validates it, and changes inputs only away from the clock edge. This way no lookup can hit a set whose attributes were never written.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

  localparam int DEF_VA_W      = 32;
  localparam int DEF_PAGE_BITS = 13;
  localparam int DEF_SET_BITS  = 6;

  localparam int CTX_W   = 4;
  localparam int CTX_LSB = 1;
  localparam int ATTR_W  = 10;

  typedef struct packed {
    logic sup_wr;
    logic sup_rd;
    logic usr_wr;
    logic usr_rd;
    logic dirty;
    logic touched;
    logic weak_order;
    logic wback;
    logic inhibit;
    logic coherent;
  } xl_attr_t;

  function automatic logic perm_allowed(xl_attr_t a, logic user, logic wr);
    case ({user, wr})
      2'b00:   return a.sup_rd;
      2'b01:   return a.sup_wr;
      2'b10:   return a.usr_rd;
      default: return a.usr_wr;
    endcase
  endfunction

endpackage

// File: rtl/dxl_match_store.sv
module dxl_match_store #(
  parameter int SET_BITS = dxl_pkg::DEF_SET_BITS,
  parameter int TAG_W    = 13,
  parameter int CTX_W    = dxl_pkg::CTX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [SET_BITS-1:0] widx,
  input  logic                wvalid,
  input  logic [CTX_W-1:0]    wctx,
  input  logic [TAG_W-1:0]    wtag,
  input  logic [SET_BITS-1:0] lk_idx,
  output logic                lk_valid,
  output logic [TAG_W-1:0]    lk_tag,
  input  logic [SET_BITS-1:0] rb_idx,
  output logic                rb_valid,
  output logic [CTX_W-1:0]    rb_ctx,
  output logic [TAG_W-1:0]    rb_tag
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [CTX_W-1:0] ctx_mem [SETS];

  // valid flags need a reset, so they live in flops
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (we) valid_q[widx] <= wvalid;
  end

  // tag and context carry no reset: plain RAM
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx] <= wtag;
      ctx_mem[widx] <= wctx;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_tag   = tag_mem[lk_idx];
  assign rb_valid = valid_q[rb_idx];
  assign rb_ctx   = ctx_mem[rb_idx];
  assign rb_tag   = tag_mem[rb_idx];
endmodule

// File: rtl/dxl_xlate_store.sv
module dxl_xlate_store #(
  parameter int SET_BITS = dxl_pkg::DEF_SET_BITS,
  parameter int PPN_W    = 19
) (
  input  logic                clk,
  input  logic                we,
  input  logic [SET_BITS-1:0] widx,
  input  logic [PPN_W-1:0]    wppn,
  input  dxl_pkg::xl_attr_t   wattr,
  input  logic [SET_BITS-1:0] lk_idx,
  output logic [PPN_W-1:0]    lk_ppn,
  output dxl_pkg::xl_attr_t   lk_attr,
  input  logic [SET_BITS-1:0] rb_idx,
  output logic [PPN_W-1:0]    rb_ppn,
  output dxl_pkg::xl_attr_t   rb_attr
);
  localparam int SETS = 1 << SET_BITS;

  logic [PPN_W-1:0]  ppn_mem  [SETS];
  dxl_pkg::xl_attr_t attr_mem [SETS];

  always_ff @(posedge clk) begin
    if (we) begin
      ppn_mem[widx]  <= wppn;
      attr_mem[widx] <= wattr;
    end
  end

  assign lk_ppn  = ppn_mem[lk_idx];
  assign lk_attr = attr_mem[lk_idx];
  assign rb_ppn  = ppn_mem[rb_idx];
  assign rb_attr = attr_mem[rb_idx];
endmodule

// File: rtl/dxl_lookup_core.sv
module dxl_lookup_core #(
  parameter int VA_W      = dxl_pkg::DEF_VA_W,
  parameter int PAGE_BITS = dxl_pkg::DEF_PAGE_BITS,
  parameter int TAG_W     = 13,
  parameter int PPN_W     = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_vld,
  input  logic              xl_en,
  input  logic              acc_user,
  input  logic              acc_wr,
  input  logic [VA_W-1:0]   acc_va,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [PPN_W-1:0]  ent_ppn,
  input  dxl_pkg::xl_attr_t ent_attr,
  output logic              res_vld,
  output logic              res_hit,
  output logic              res_miss,
  output logic [VA_W-1:0]   res_pa,
  output logic              res_ci,
  output logic              res_fault
);
  logic tag_eq, hit_now, perm_ok;

  assign tag_eq  = (ent_tag == acc_va[VA_W-1 -: TAG_W]);
  assign hit_now = ent_valid && tag_eq;
  assign perm_ok = dxl_pkg::perm_allowed(ent_attr, acc_user, acc_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_pa    <= '0;
      res_ci    <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_vld   <= acc_vld;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_pa    <= '0;
      res_ci    <= 1'b0;
      res_fault <= 1'b0;
      if (acc_vld) begin
        if (!xl_en) begin
          res_pa <= acc_va;
          res_ci <= acc_va[VA_W-1];
        end else if (hit_now) begin
          res_hit   <= 1'b1;
          res_pa    <= {ent_ppn, acc_va[PAGE_BITS-1:0]};
          res_ci    <= ent_attr.inhibit;
          res_fault <= !perm_ok;
        end else begin
          res_miss  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dxl_tlb.sv
module dxl_tlb #(
  parameter int VA_W      = dxl_pkg::DEF_VA_W,
  parameter int PAGE_BITS = dxl_pkg::DEF_PAGE_BITS,
  parameter int SET_BITS  = dxl_pkg::DEF_SET_BITS,
  parameter int REG_AW    = 8,
  parameter int SEL_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_vld,
  input  logic              xl_en,
  input  logic              acc_user,
  input  logic              acc_wr,
  input  logic [VA_W-1:0]   acc_va,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [VA_W-1:0]   reg_wdata,
  output logic [VA_W-1:0]   reg_rdata,
  output logic              res_vld,
  output logic              res_hit,
  output logic              res_miss,
  output logic [VA_W-1:0]   res_pa,
  output logic              res_ci,
  output logic              res_fault
);
  import dxl_pkg::*;

  localparam int TAG_W = VA_W - PAGE_BITS - SET_BITS;
  localparam int PPN_W = VA_W - PAGE_BITS;

  logic                sel_xlate;
  logic [SET_BITS-1:0] reg_idx, lk_idx;
  logic                we_match, we_xlate;

  assign sel_xlate = reg_addr[SEL_BIT];
  assign reg_idx   = reg_addr[SET_BITS-1:0];
  assign lk_idx    = acc_va[PAGE_BITS +: SET_BITS];
  assign we_match  = reg_we && !sel_xlate;
  assign we_xlate  = reg_we &&  sel_xlate;

  logic               lk_valid, rb_valid;
  logic [TAG_W-1:0]   lk_tag, rb_tag;
  logic [CTX_W-1:0]   rb_ctx;
  logic [PPN_W-1:0]   lk_ppn, rb_ppn;
  xl_attr_t           lk_attr, rb_attr;

  dxl_match_store #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_match (
    .clk(clk), .rst(rst), .we(we_match), .widx(reg_idx),
    .wvalid(reg_wdata[0]), .wctx(reg_wdata[CTX_LSB +: CTX_W]),
    .wtag(reg_wdata[VA_W-1 -: TAG_W]),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag),
    .rb_idx(reg_idx), .rb_valid(rb_valid), .rb_ctx(rb_ctx), .rb_tag(rb_tag)
  );

  dxl_xlate_store #(.SET_BITS(SET_BITS), .PPN_W(PPN_W)) u_xlate (
    .clk(clk), .we(we_xlate), .widx(reg_idx),
    .wppn(reg_wdata[VA_W-1 -: PPN_W]), .wattr(xl_attr_t'(reg_wdata[ATTR_W-1:0])),
    .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_attr(lk_attr),
    .rb_idx(reg_idx), .rb_ppn(rb_ppn), .rb_attr(rb_attr)
  );

  dxl_lookup_core #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_core (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .xl_en(xl_en),
    .acc_user(acc_user), .acc_wr(acc_wr), .acc_va(acc_va),
    .ent_valid(lk_valid), .ent_tag(lk_tag), .ent_ppn(lk_ppn), .ent_attr(lk_attr),
    .res_vld(res_vld), .res_hit(res_hit), .res_miss(res_miss),
    .res_pa(res_pa), .res_ci(res_ci), .res_fault(res_fault)
  );

  logic [VA_W-1:0] rd_match, rd_xlate;

  always_comb begin
    rd_match = '0;
    rd_match[0] = rb_valid;
    rd_match[CTX_LSB +: CTX_W] = rb_ctx;
    rd_match[VA_W-1 -: TAG_W] = rb_tag;
    rd_xlate = '0;
    rd_xlate[ATTR_W-1:0] = rb_attr;
    rd_xlate[VA_W-1 -: PPN_W] = rb_ppn;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= sel_xlate ? rd_xlate : rd_match;
  end

  logic unused_top;
  assign unused_top = ^{reg_addr[SEL_BIT-1:SET_BITS], reg_wdata[PAGE_BITS-1:ATTR_W]};
endmodule

// File: rtl/dxl_tlb_chk.sv
module dxl_tlb_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int REG_AW    = 8,
  parameter int SEL_BIT   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_vld,
  input logic              xl_en,
  input logic [VA_W-1:0]   acc_va,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              res_vld,
  input logic              res_hit,
  input logic              res_miss,
  input logic [VA_W-1:0]   res_pa,
  input logic              res_ci,
  input logic              res_fault
);
  logic any_fill;
  always_ff @(posedge clk) begin
    if (rst) any_fill <= 1'b0;
    else if (reg_we && !reg_addr[SEL_BIT]) any_fill <= 1'b1;
  end

  logic unused_chk;
  assign unused_chk = ^reg_addr;

  assert_reset_idle_R6: assert property (@(posedge clk)
    rst |=> (!res_vld && !res_hit && !res_miss && !res_fault && !res_ci && res_pa == '0));

  assert_empty_miss_R1: assert property (@(posedge clk) disable iff (rst)
    (!any_fill && acc_vld && xl_en) |=> res_miss);

  assert_hit_xor_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && xl_en) |=> (res_hit != res_miss));

  assert_miss_clean_R2: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (res_pa == '0 && !res_ci && !res_fault));

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && xl_en) |=> (!res_hit || res_pa[PAGE_BITS-1:0] == $past(acc_va[PAGE_BITS-1:0])));

  assert_fault_needs_hit_R4: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> res_hit);

  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && !xl_en) |=> (res_pa == $past(acc_va) && res_ci == $past(acc_va[VA_W-1])
                             && !res_hit && !res_miss && !res_fault));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |=> (!res_vld && !res_hit && !res_miss && res_pa == '0));
endmodule

bind dxl_tlb dxl_tlb_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .REG_AW(REG_AW), .SEL_BIT(SEL_BIT)) u_chk (
  .clk(clk), .rst(rst), .acc_vld(acc_vld), .xl_en(xl_en), .acc_va(acc_va),
  .reg_we(reg_we), .reg_addr(reg_addr), .res_vld(res_vld), .res_hit(res_hit),
  .res_miss(res_miss), .res_pa(res_pa), .res_ci(res_ci), .res_fault(res_fault)
);

// File: tb/dxl_tlb_test.sv
module dxl_tlb_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_vld = 1'b0, xl_en = 1'b0, acc_user = 1'b0, acc_wr = 1'b0;
  logic [31:0] acc_va = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, res_pa;
  logic        res_vld, res_hit, res_miss, res_ci, res_fault;

  always #5 clk = ~clk;

  dxl_tlb uut (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .xl_en(xl_en), .acc_user(acc_user),
    .acc_wr(acc_wr), .acc_va(acc_va), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_vld(res_vld), .res_hit(res_hit),
    .res_miss(res_miss), .res_pa(res_pa), .res_ci(res_ci), .res_fault(res_fault)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_res(string req, logic h, logic m, logic [31:0] pa, logic ci, logic f);
    check(req, "res_vld", {31'b0, res_vld}, 32'd1);
    check(req, "res_hit", {31'b0, res_hit}, {31'b0, h});
    check(req, "res_miss", {31'b0, res_miss}, {31'b0, m});
    check(req, "res_pa", res_pa, pa);
    check(req, "res_ci", {31'b0, res_ci}, {31'b0, ci});
    check(req, "res_fault", {31'b0, res_fault}, {31'b0, f});
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  typedef struct packed {
    logic        en, user, wr;
    logic [31:0] va;
    logic        hit, miss;
    logic [31:0] pa;
    logic        ci, fault;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,1'b0,32'h52D0A123, 1'b1,1'b0,32'h2468A123, 1'b1,1'b0, 8'd3}, // R3 user read allowed
    '{1'b1,1'b1,1'b1,32'h52D0A123, 1'b1,1'b0,32'h2468A123, 1'b1,1'b1, 8'd4}, // R4 user write denied
    '{1'b1,1'b0,1'b1,32'h52D0A000, 1'b1,1'b0,32'h2468A000, 1'b1,1'b0, 8'd4}, // R4 sup write allowed
    '{1'b1,1'b0,1'b0,32'hFFFFFFFF, 1'b1,1'b0,32'h00003FFF, 1'b0,1'b1, 8'd4}, // R4 sup read denied
    '{1'b1,1'b0,1'b1,32'hFFFFFFFF, 1'b1,1'b0,32'h00003FFF, 1'b0,1'b0, 8'd3}, // R3 top set, top offset
    '{1'b1,1'b1,1'b0,32'hFFFFE000, 1'b1,1'b0,32'h00002000, 1'b0,1'b1, 8'd4}, // R4 user read denied
    '{1'b1,1'b0,1'b0,32'h52D8A123, 1'b0,1'b1,32'h00000000, 1'b0,1'b0, 8'd2}, // R2 tag mismatch
    '{1'b1,1'b0,1'b0,32'h52D0C000, 1'b0,1'b1,32'h00000000, 1'b0,1'b0, 8'd2}, // R2 invalid set
    '{1'b0,1'b0,1'b0,32'h80001234, 1'b0,1'b0,32'h80001234, 1'b1,1'b0, 8'd5}, // R5 upper half uncached
    '{1'b0,1'b1,1'b1,32'h7FFFFFFF, 1'b0,1'b0,32'h7FFFFFFF, 1'b0,1'b0, 8'd5}  // R5 lower half cached
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R6: reset state
    tick(); tick();
    check("R6", "res_vld in reset", {31'b0, res_vld}, 32'd0);
    check("R6", "res_pa in reset", res_pa, 32'd0);
    rst = 1'b0;
    tick();

    // R1: empty table misses
    acc_vld = 1; xl_en = 1; acc_va = 32'h52D0A123;
    tick();
    check_res("R1", 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
    acc_vld = 0;
    tick();
    check("R6", "res_vld idle", {31'b0, res_vld}, 32'd0);

    // fill: reserved bits set in write data
    reg_write(8'h85, 32'h2468BF42);
    reg_write(8'h05, 32'h52D0FFFF);
    reg_write(8'hBF, 32'h00002200);
    reg_write(8'h3F, 32'hFFF80001);

    // R8 readback
    reg_addr = 8'h05; tick();
    check("R8", "match readback", reg_rdata, 32'h52D0001F);
    reg_addr = 8'h85; tick();
    check("R8", "translate readback", reg_rdata, 32'h2468A342);
    reg_addr = 8'hBF; tick();
    check("R8", "translate readback 63", reg_rdata, 32'h00002200);

    for (int i = 0; i < NV; i++) begin
      acc_vld = 1; xl_en = TBL[i].en; acc_user = TBL[i].user; acc_wr = TBL[i].wr;
      acc_va = TBL[i].va;
      tick();
      check_res($sformatf("R%0d", TBL[i].req), TBL[i].hit, TBL[i].miss,
                TBL[i].pa, TBL[i].ci, TBL[i].fault);
    end

    // R7: write visibility timing
    acc_vld = 0;
    reg_write(8'h86, 32'h00004100);
    acc_vld = 1; xl_en = 1; acc_user = 0; acc_wr = 0; acc_va = 32'h52D0C010;
    reg_we = 1; reg_addr = 8'h06; reg_wdata = 32'h52D00001;
    tick();
    reg_we = 0;
    check_res("R7", 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
    tick();
    check_res("R7", 1'b1, 1'b0, 32'h00004010, 1'b0, 1'b0);

    // R2: invalidated set misses
    reg_we = 1; reg_wdata = 32'h52D00000;
    tick();
    reg_we = 0;
    tick();
    check_res("R2", 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
    acc_vld = 0;
    tick();
    finish_run();
  end
endmodule